// File: doc/BRIEF.md
# Power Threshold Supervisor Register Block

This block watches a live consumed-power sample and keeps two programmable alarm levels in whole watts: a warning level and a critical level. Each sample cycle it compares the sample against both levels and raises the matching alarm pin when the sample has reached the level. Software programs the levels through a 64-bit register port with byte enables. Software can read the live sample, a latency-tolerance flag that sits next to it, and the alarm state.

The block also stores two power-limit words, one for the host processor and one for the accelerator. Each word is 15 bits in tenths of a watt plus an enable bit. The block does not enforce either limit. It only drives an effective-limit output per channel, and that output is zero whenever the channel's enable is clear.

Register reads go through a two-state access machine. BUS_IDLE moves to BUS_RESP when a read is requested. BUS_RESP stays in BUS_RESP while reads keep arriving and returns to BUS_IDLE when none is requested. Read data is valid for exactly the cycles spent in BUS_RESP. Writes take effect at the clock edge where they are presented, in either state.

Top module: `pwrmon_regs`

## Requirements
- R1: After reset both alarm levels read 0x7F. Both limit words read 0 with their enables clear. Both alarm pins and both effective-limit outputs are 0.
- R2: A read of offset 0x08 returns the power sample in bits [17:0] and the latency-tolerance flag in bit 18, with all other bits zero. The values are those present at the clock edge that accepts the read.
- R3: At offset 0x10 the warning level occupies bits [6:0] (byte lane 0) and the critical level occupies bits [14:8] (byte lane 1). A write updates only the levels whose byte enable is set and leaves the other level unchanged.
- R4: A level byte written with a value above 0x7F is stored as 0x7F.
- R5: The warning pin and bit 16 of offset 0x10 are 1 exactly when the sample, compared as an 18-bit unsigned value, is greater than or equal to the zero-extended warning level. They follow the sample and the level one cycle later.
- R6: The critical pin and bit 17 of offset 0x10 follow the same rule against the critical level.
- R7: Offset 0x18 (host) and offset 0x20 (accelerator) each hold a limit in bits [14:0] and an enable in bit 15. A write updates only the byte lanes 0 and 1 whose enable is set, and the word reads back as stored.
- R8: Each effective-limit output equals its stored limit when that channel's enable is 1, and equals 0 when the enable is 0.
- R9: Writes to offset 0x08, writes to bits 16 and 17 of offset 0x10, and writes to byte lanes 2 to 7 change nothing.
- R10: A read of any offset other than 0x08, 0x10, 0x18 and 0x20 returns zero.
- R11: Read valid is asserted in the cycle after each cycle that presents a read and in no other cycle. Back-to-back reads return their data in consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_sample_i | input | 18 | Consumed power in whole watts |
| lat_tol_i | input | 1 | Latency-tolerance flag |
| reg_rd_i | input | 1 | Read request |
| reg_wr_i | input | 1 | Write request |
| reg_addr_i | input | 6 | Byte offset of the register |
| reg_be_i | input | 8 | Byte enables for writes |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data |
| reg_rvalid_o | output | 1 | Read data valid |
| alarm_warn_o | output | 1 | Warning-level alarm |
| alarm_crit_o | output | 1 | Critical-level alarm |
| host_lim_eff_o | output | 15 | Effective host limit, 0.1 W units |
| accel_lim_eff_o | output | 15 | Effective accelerator limit, 0.1 W units |

## Verification
The comparators are driven with samples just below, equal to and just above each level. This separates a greater-or-equal comparison from a strict greater-than one. A sample with only bit 17 set, checked against the highest level, exposes any truncation of the sample in the comparison. Level writes use single byte enables, over-range values and a level change under a steady sample. These tell apart lane crosstalk, a missing clamp and alarms that only react to the sample. The limit words are written with the enable on, then off, then with only the upper lane enabled, so that stored data and effective output are checked separately.

// File: rtl/pwrmon_pkg.sv
package pwrmon_pkg;

    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_THR    = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_HOST   = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_ACCEL  = 6'h20;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_THR,
        SEL_HOST,
        SEL_ACCEL
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        s = SEL_NONE;
        if (a == OFS_STATUS) s = SEL_STATUS;
        if (a == OFS_THR)    s = SEL_THR;
        if (a == OFS_HOST)   s = SEL_HOST;
        if (a == OFS_ACCEL)  s = SEL_ACCEL;
        return s;
    endfunction

endpackage

// File: rtl/pwrmon_bus.sv
module pwrmon_bus
    import pwrmon_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     rword_i,
    output reg_sel_e          sel_o,
    output logic              wr_thr_o,
    output logic              wr_host_o,
    output logic              wr_accel_o,
    output logic [DW-1:0]     rdata_o,
    output logic              rvalid_o
);

    bus_state_e state_q;
    bus_state_e state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_i)  state_d = BUS_RESP;
            BUS_RESP: if (!rd_i) state_d = BUS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // read data capture
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_o <= '0;
        else if (rd_i) rdata_o <= rword_i;
    end

    // outputs
    always_comb begin
        sel_o      = decode_ofs(addr_i);
        rvalid_o   = (state_q == BUS_RESP);
        wr_thr_o   = wr_i && (sel_o == SEL_THR);
        wr_host_o  = wr_i && (sel_o == SEL_HOST);
        wr_accel_o = wr_i && (sel_o == SEL_ACCEL);
    end

endmodule

// File: rtl/pwrmon_thresh.sv
module pwrmon_thresh #(
    parameter int PWR_W = 18,
    parameter int THR_W = 7,
    parameter int NUM   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_i,
    input  logic [NUM-1:0]             be_i,
    input  logic [8*NUM-1:0]           wdata_i,
    input  logic [PWR_W-1:0]           pwr_i,
    output logic [NUM-1:0][THR_W-1:0]  thr_o,
    output logic [NUM-1:0]             alarm_o
);

    localparam logic [THR_W-1:0] THR_MAX = '1;
    localparam int               PAD     = PWR_W - THR_W;

    for (genvar g = 0; g < NUM; g++) begin : g_lvl
        logic [7:0]       lane;
        logic [THR_W-1:0] sat;
        logic [THR_W-1:0] thr_q;
        logic             hit_q;

        assign lane = wdata_i[8*g +: 8];

        // clamp over-range values to the largest level
        always_comb begin
            if (lane > 8'(THR_MAX)) sat = THR_MAX;
            else                    sat = lane[THR_W-1:0];
        end

        always_ff @(posedge clk) begin
            if (!rst_n)                thr_q <= THR_MAX;
            else if (wr_i && be_i[g])  thr_q <= sat;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) hit_q <= 1'b0;
            else        hit_q <= (pwr_i >= {{PAD{1'b0}}, thr_q});
        end

        assign thr_o[g]   = thr_q;
        assign alarm_o[g] = hit_q;
    end

endmodule

// File: rtl/pwrmon_limit.sv
module pwrmon_limit #(
    parameter int LIM_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [1:0]       be_i,
    input  logic [15:0]      wdata_i,
    output logic [LIM_W:0]   raw_o,
    output logic [LIM_W-1:0] eff_o
);

    localparam int W = LIM_W + 1;

    logic [W-1:0] q;
    logic [15:0]  mask;
    logic [15:0]  merged;

    always_comb begin
        mask   = {{8{be_i[1]}}, {8{be_i[0]}}};
        merged = (16'(q) & ~mask) | (wdata_i & mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (wr_i) q <= merged[W-1:0];
    end

    assign raw_o = q;
    assign eff_o = q[LIM_W] ? q[LIM_W-1:0] : '0;

endmodule

// File: rtl/pwrmon_regs.sv
module pwrmon_regs
    import pwrmon_pkg::*;
#(
    parameter int PWR_W = 18,
    parameter int THR_W = 7,
    parameter int LIM_W = 15,
    parameter int DW    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PWR_W-1:0]  pwr_sample_i,
    input  logic              lat_tol_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DW/8-1:0]   reg_be_i,
    input  logic [DW-1:0]     reg_wdata_i,
    output logic [DW-1:0]     reg_rdata_o,
    output logic              reg_rvalid_o,
    output logic              alarm_warn_o,
    output logic              alarm_crit_o,
    output logic [LIM_W-1:0]  host_lim_eff_o,
    output logic [LIM_W-1:0]  accel_lim_eff_o
);

    localparam int NLVL  = 2;
    localparam int NLIM  = 2;
    localparam int ALM_B = 16;

    reg_sel_e                  sel;
    logic                      wr_thr;
    logic                      wr_host;
    logic                      wr_accel;
    logic [DW-1:0]             rword;
    logic [NLVL-1:0][THR_W-1:0] thr_w;
    logic [NLVL-1:0]           alarm_w;
    logic [NLIM-1:0]           lim_wr;
    logic [NLIM-1:0][LIM_W:0]  lim_raw;
    logic [NLIM-1:0][LIM_W-1:0] lim_eff;
    logic                      unused_bits;

    assign unused_bits = ^{reg_wdata_i[DW-1:16], reg_be_i[DW/8-1:2]};

    pwrmon_bus #(.DW(DW)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (reg_rd_i),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .rword_i    (rword),
        .sel_o      (sel),
        .wr_thr_o   (wr_thr),
        .wr_host_o  (wr_host),
        .wr_accel_o (wr_accel),
        .rdata_o    (reg_rdata_o),
        .rvalid_o   (reg_rvalid_o)
    );

    pwrmon_thresh #(.PWR_W(PWR_W), .THR_W(THR_W), .NUM(NLVL)) u_thr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_thr),
        .be_i    (reg_be_i[NLVL-1:0]),
        .wdata_i (reg_wdata_i[8*NLVL-1:0]),
        .pwr_i   (pwr_sample_i),
        .thr_o   (thr_w),
        .alarm_o (alarm_w)
    );

    assign lim_wr = {wr_accel, wr_host};

    for (genvar g = 0; g < NLIM; g++) begin : g_lim
        pwrmon_limit #(.LIM_W(LIM_W)) u_lim (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (lim_wr[g]),
            .be_i    (reg_be_i[1:0]),
            .wdata_i (reg_wdata_i[15:0]),
            .raw_o   (lim_raw[g]),
            .eff_o   (lim_eff[g])
        );
    end

    // read word selection
    always_comb begin
        rword = '0;
        unique case (sel)
            SEL_STATUS: rword = DW'({lat_tol_i, pwr_sample_i});
            SEL_THR: begin
                rword[THR_W-1:0]      = thr_w[0];
                rword[8 +: THR_W]     = thr_w[1];
                rword[ALM_B +: NLVL]  = alarm_w;
            end
            SEL_HOST:  rword = DW'(lim_raw[0]);
            SEL_ACCEL: rword = DW'(lim_raw[1]);
            default:   rword = '0;
        endcase
    end

    assign alarm_warn_o    = alarm_w[0];
    assign alarm_crit_o    = alarm_w[1];
    assign host_lim_eff_o  = lim_eff[0];
    assign accel_lim_eff_o = lim_eff[1];

endmodule

// File: rtl/pwrmon_regs_chk.sv
module pwrmon_regs_chk
    import pwrmon_pkg::*;
#(
    parameter int PWR_W = 18,
    parameter int THR_W = 7,
    parameter int LIM_W = 15,
    parameter int DW    = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PWR_W-1:0]  pwr,
    input logic              rd,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [DW/8-1:0]   be,
    input logic [DW-1:0]     wdata,
    input logic              rvalid,
    input logic              warn,
    input logic              crit,
    input logic [LIM_W-1:0]  host_eff,
    input logic [THR_W-1:0]  thr1,
    input logic [THR_W-1:0]  thr2
);

    localparam int PAD = PWR_W - THR_W;

    // R11
    rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);

    // R11
    rvalid_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd));

    // R5
    warn_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (warn == ($past(pwr) >= $past({{PAD{1'b0}}, thr1}))));

    // R6
    crit_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (crit == ($past(pwr) >= $past({{PAD{1'b0}}, thr2}))));

    // R4
    warn_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_THR && be[0] && wdata[7]) |=> (thr1 == '1));

    // R8
    host_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_HOST && be[1] && !wdata[15]) |=> (host_eff == '0));

endmodule

bind pwrmon_regs pwrmon_regs_chk #(
    .PWR_W(PWR_W), .THR_W(THR_W), .LIM_W(LIM_W), .DW(DW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr      (pwr_sample_i),
    .rd       (reg_rd_i),
    .wr       (reg_wr_i),
    .addr     (reg_addr_i),
    .be       (reg_be_i),
    .wdata    (reg_wdata_i),
    .rvalid   (reg_rvalid_o),
    .warn     (alarm_warn_o),
    .crit     (alarm_crit_o),
    .host_eff (host_lim_eff_o),
    .thr1     (thr_w[0]),
    .thr2     (thr_w[1])
);

// File: tb/pwrmon_regs_test.sv
module pwrmon_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] pwr = '0;
    logic        ltr = 1'b0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [7:0]  be = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        rvalid;
    logic        warn;
    logic        crit;
    logic [14:0] host_eff;
    logic [14:0] accel_eff;

    int checks = 0;
    int errors = 0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    logic [6:0]  m_t1 = 7'h7F;
    logic [6:0]  m_t2 = 7'h7F;

    always #5 clk = ~clk;

    pwrmon_regs uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .pwr_sample_i    (pwr),
        .lat_tol_i       (ltr),
        .reg_rd_i        (rd),
        .reg_wr_i        (wr),
        .reg_addr_i      (addr),
        .reg_be_i        (be),
        .reg_wdata_i     (wdata),
        .reg_rdata_o     (rdata),
        .reg_rvalid_o    (rvalid),
        .alarm_warn_o    (warn),
        .alarm_crit_o    (crit),
        .host_lim_eff_o  (host_eff),
        .accel_lim_eff_o (accel_eff)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                chk("R11 unexpected rvalid", 64'd1, 64'd0);
            end else begin
                chk(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    function automatic logic [63:0] thr_word(input logic [17:0] p);
        logic [63:0] w;
        w = '0;
        w[6:0]  = m_t1;
        w[14:8] = m_t2;
        w[16]   = (p >= {11'd0, m_t1});
        w[17]   = (p >= {11'd0, m_t2});
        return w;
    endfunction

    task automatic do_write(input logic [5:0] a, input logic [7:0] b, input logic [63:0] d);
        wr = 1'b1; addr = a; be = b; wdata = d;
        @(negedge clk);
        wr = 1'b0; be = '0; wdata = '0;
    endtask

    task automatic do_read(input logic [5:0] a, input logic [63:0] e, input string tag);
        rd = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic set_pwr(input logic [17:0] p);
        pwr = p;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 warn", 64'(warn), 64'd0);
        chk("R1 crit", 64'(crit), 64'd0);
        chk("R1 host eff", 64'(host_eff), 64'd0);
        chk("R1 accel eff", 64'(accel_eff), 64'd0);
        chk("R1 rvalid", 64'(rvalid), 64'd0);
        do_read(6'h10, 64'h7F7F, "R1 levels");
        do_read(6'h18, 64'h0, "R1 host word");
        do_read(6'h20, 64'h0, "R1 accel word");

        // R2 status
        pwr = 18'h2A5C3; ltr = 1'b1;
        do_read(6'h08, 64'h6A5C3, "R2 status flag set");
        pwr = 18'h5; ltr = 1'b0;
        do_read(6'h08, 64'h5, "R2 status flag clear");
        @(negedge clk);

        // R3 independent lanes
        do_write(6'h10, 8'h01, 64'hC520); m_t1 = 7'h20;
        do_read(6'h10, thr_word(pwr), "R3 warn lane only");
        do_write(6'h10, 8'h02, 64'h3355); m_t2 = 7'h33;
        do_read(6'h10, thr_word(pwr), "R3 crit lane only");

        // R4 clamp
        do_write(6'h10, 8'h01, 64'hC5); m_t1 = 7'h7F;
        do_read(6'h10, thr_word(pwr), "R4 warn clamp");
        do_write(6'h10, 8'h02, 64'h8000); m_t2 = 7'h7F;
        do_read(6'h10, thr_word(pwr), "R4 crit clamp");
        do_write(6'h10, 8'h03, 64'h3310); m_t1 = 7'h10; m_t2 = 7'h33;
        @(negedge clk);

        // R5 / R6 comparisons
        set_pwr(18'h0F);
        chk("R5 below warn", 64'(warn), 64'd0);
        chk("R6 below crit", 64'(crit), 64'd0);
        set_pwr(18'h10);
        chk("R5 equal warn", 64'(warn), 64'd1);
        chk("R6 below crit", 64'(crit), 64'd0);
        do_read(6'h10, thr_word(pwr), "R5 status bit");
        set_pwr(18'h33);
        chk("R6 equal crit", 64'(crit), 64'd1);
        do_read(6'h10, thr_word(pwr), "R6 status bit");
        set_pwr(18'h32);
        chk("R6 just below crit", 64'(crit), 64'd0);
        chk("R5 above warn", 64'(warn), 64'd1);
        do_write(6'h10, 8'h03, 64'h7F7F); m_t1 = 7'h7F; m_t2 = 7'h7F;
        set_pwr(18'h20000);
        chk("R5 wide sample", 64'(warn), 64'd1);
        chk("R6 wide sample", 64'(crit), 64'd1);
        do_write(6'h10, 8'h03, 64'h3310); m_t1 = 7'h10; m_t2 = 7'h33;
        set_pwr(18'h40);
        chk("R6 high sample", 64'(crit), 64'd1);
        do_write(6'h10, 8'h02, 64'h4100); m_t2 = 7'h41;
        @(negedge clk);
        chk("R6 level raised", 64'(crit), 64'd0);
        chk("R5 level kept", 64'(warn), 64'd1);

        // R9 read-only parts
        do_write(6'h08, 8'hFF, '1);
        do_read(6'h08, 64'h40, "R9 status unchanged");
        do_write(6'h10, 8'hFC, '1);
        @(negedge clk);
        do_read(6'h10, thr_word(pwr), "R9 level word unchanged");
        chk("R9 warn pin", 64'(warn), 64'd1);
        chk("R9 crit pin", 64'(crit), 64'd0);

        // R7 / R8 limits
        do_write(6'h18, 8'h03, 64'h9234);
        chk("R8 host enabled", 64'(host_eff), 64'h1234);
        do_read(6'h18, 64'h9234, "R7 host word");
        do_write(6'h20, 8'h03, 64'h0ABC);
        chk("R8 accel disabled", 64'(accel_eff), 64'h0);
        do_read(6'h20, 64'h0ABC, "R7 accel word");
        do_write(6'h20, 8'h02, 64'h8000);
        chk("R8 accel enabled", 64'(accel_eff), 64'h00BC);
        do_read(6'h20, 64'h80BC, "R7 accel upper lane");
        do_write(6'h18, 8'h02, 64'h0);
        chk("R8 host disabled", 64'(host_eff), 64'h0);
        do_read(6'h18, 64'h0034, "R7 host upper lane");

        // R10 unmapped
        do_read(6'h00, 64'h0, "R10 offset 0x00");
        do_read(6'h28, 64'h0, "R10 offset 0x28");
        do_read(6'h3F, 64'h0, "R10 offset 0x3F");

        // R11 back-to-back
        rd = 1'b1; addr = 6'h08;
        exp_q.push_back(64'h40); tag_q.push_back("R11 first of pair");
        @(negedge clk);
        addr = 6'h18;
        exp_q.push_back(64'h0034); tag_q.push_back("R11 second of pair");
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
        chk("R11 rvalid drops", 64'(rvalid), 64'd0);
        chk("R11 queue drained", 64'(exp_q.size()), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule